// File: doc/BRIEF.md
# Supply-Fail Deselect and Recovery Controller

This block is the digital half of the supply protection for a battery-backed static memory with a built-in clock. Comparators outside the block produce synchronized flags for the supply level. One flag is high above the upper power-fail threshold, one above the lower threshold, and one above the battery switchover level. From these flags and a millisecond tick, the controller decides three things: whether the array may be accessed, whether the data pins must float, and whether the storage runs from the battery.

When the supply drops out of tolerance, access is withdrawn in the same cycle, so a write in flight is cut short. Below the switchover level the battery is selected. When the supply returns, access stays blocked until the upper flag has stayed high for a programmable number of millisecond ticks (`REC_MS`, intended range 40 to 200, default 100). If the flag drops earlier, the count starts again.

The controller also keeps a battery-low flag. A check runs once at each power-up and at every day rollover, as long as the oscillator is running. A failing check sets the flag only when the enable bit is 1. Any check that passes clears it. No check is made while the block runs on battery.

The states are BATT, PROT, RECOV, CHECK and ACTIVE, and they change as follows:
- BATT→PROT: the switchover flag rises.
- PROT→RECOV: both threshold flags are high.
- RECOV→PROT: a threshold flag drops, which restarts the timer.
- RECOV→CHECK: the `REC_MS`-th tick arrives.
- CHECK→ACTIVE: taken on the next cycle, with the power-up battery check made on that edge.
- ACTIVE→PROT: a threshold flag drops.
- any→BATT: the switchover flag falls. This has priority over every other transition.

Top module: `pwr_guard_ctrl`

## Requirements
- R1: During and after reset the block is in BATT: `acc_en`=0, `wr_en`=0, `hiz_force`=1, `bat_sel`=1 and `batt_low`=0.
- R2: `bat_sel` is 1 in the cycle after `sup_so` is sampled low. It is 0 in the cycle after `sup_so` is sampled high, provided it was not low.
- R3: `acc_en` and `wr_en` are 0 in any cycle where `sup_hi` or `sup_lo` is 0. This takes effect combinationally, in the same cycle, so a write in progress is aborted.
- R4: After both threshold flags rise, `acc_en` stays 0 until `REC_MS` ticks have been sampled in RECOV. It becomes 1 one clock after the edge that samples the last of those ticks.
- R5: If a threshold flag drops during RECOV, the tick count restarts from zero once the flags return.
- R6: With access granted, `wr_en`=1 exactly when `cs1_n`=0, `cs2`=1 and `we_n`=0. During a write `hiz_force` is 1.
- R7: With access granted, `hiz_force`=0 exactly when `cs1_n`=0, `cs2`=1, `we_n`=1 and `oe_n`=0. In every other case `hiz_force`=1.
- R8: While access is not granted, all 16 combinations of `cs1_n`, `cs2`, `oe_n` and `we_n` give `wr_en`=0 and `hiz_force`=1.
- R9: The power-up check (on the CHECK→ACTIVE edge) sets `batt_low` when `batt_ok`=0 and `blow_en`=1.
- R10: A failing check with `blow_en`=0 leaves `batt_low` unchanged.
- R11: A `day_roll` pulse in ACTIVE triggers a check only while `osc_run`=1.
- R12: `batt_low` stays 1 until a later check sees `batt_ok`=1, which clears it.
- R13: In BATT, `batt_low` never changes, whatever `day_roll` and `batt_ok` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sup_hi | input | 1 | Supply above upper power-fail threshold |
| sup_lo | input | 1 | Supply above lower power-fail threshold |
| sup_so | input | 1 | Supply above battery switchover level |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| cs1_n | input | 1 | Chip enable 1, active low |
| cs2 | input | 1 | Chip enable 2, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| day_roll | input | 1 | Day rollover pulse from the clock |
| osc_run | input | 1 | Oscillator running |
| batt_ok | input | 1 | Battery comparator: battery above low limit |
| blow_en | input | 1 | Battery-low enable bit |
| acc_en | output | 1 | Internal access enable (0 = deselected and write-protected) |
| wr_en | output | 1 | Write strobe into the array |
| hiz_force | output | 1 | Force data pins to high impedance |
| bat_sel | output | 1 | Select battery as storage supply |
| batt_low | output | 1 | Battery-low flag |

## Verification
The hardest situation to reach is a recovery interrupted part-way through its count. To get there, the bench builds the design with a three-tick recovery and counts ticks one cycle at a time. It drops the upper flag after two ticks and then shows that two further ticks still do not grant access. A design that kept the old count would already grant access at that point. The battery flag's persistence is reached by taking the supply fully into battery mode with rollover pulses and a good battery applied, then showing the flag only clears on the following power-up check.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
    typedef enum logic [2:0] {
        PG_BATT   = 3'd0,
        PG_PROT   = 3'd1,
        PG_RECOV  = 3'd2,
        PG_CHECK  = 3'd3,
        PG_ACTIVE = 3'd4
    } pg_state_t;
endpackage

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
    import pwr_guard_pkg::*;
#(
    parameter int REC_MS = 100
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sup_hi,
    input  logic      sup_lo,
    input  logic      sup_so,
    input  logic      ms_tick,
    output pg_state_t state_q,
    output logic      in_batt,
    output logic      in_check,
    output logic      in_active
);
    localparam int CNT_W = $clog2(REC_MS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(REC_MS - 1);

    pg_state_t        state_d;
    logic [CNT_W-1:0] rec_cnt;
    logic             sup_ok;

    assign sup_ok = sup_hi && sup_lo;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_BATT;
        else        state_q <= state_d;
    end

    // recovery tick counter, cleared outside RECOV
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rec_cnt <= '0;
        else if (state_q != PG_RECOV) rec_cnt <= '0;
        else if (ms_tick)            rec_cnt <= rec_cnt + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_BATT:   if (sup_so) state_d = PG_PROT;
            PG_PROT: begin
                if (!sup_so)     state_d = PG_BATT;
                else if (sup_ok) state_d = PG_RECOV;
            end
            PG_RECOV: begin
                if (!sup_so)                            state_d = PG_BATT;
                else if (!sup_ok)                       state_d = PG_PROT;
                else if (ms_tick && rec_cnt == LAST_TICK) state_d = PG_CHECK;
            end
            PG_CHECK: begin
                if (!sup_so)      state_d = PG_BATT;
                else if (!sup_ok) state_d = PG_PROT;
                else              state_d = PG_ACTIVE;
            end
            PG_ACTIVE: begin
                if (!sup_so)      state_d = PG_BATT;
                else if (!sup_ok) state_d = PG_PROT;
            end
            default:              state_d = PG_BATT;
        endcase
    end

    // state-derived outputs
    always_comb begin
        in_batt   = 1'b0;
        in_check  = 1'b0;
        in_active = 1'b0;
        unique case (state_q)
            PG_BATT:   in_batt   = 1'b1;
            PG_CHECK:  in_check  = 1'b1;
            PG_ACTIVE: in_active = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_guard_batt.sv
module pwr_guard_batt (
    input  logic clk,
    input  logic rst_n,
    input  logic in_check,
    input  logic in_active,
    input  logic day_roll,
    input  logic osc_run,
    input  logic batt_ok,
    input  logic blow_en,
    output logic batt_low
);
    logic chk_now;

    assign chk_now = in_check || (in_active && day_roll && osc_run);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    batt_low <= 1'b0;
        else if (chk_now && batt_ok)   batt_low <= 1'b0;
        else if (chk_now && blow_en)   batt_low <= 1'b1;
    end
endmodule

// File: rtl/pwr_guard_decode.sv
module pwr_guard_decode (
    input  logic acc_en,
    input  logic cs1_n,
    input  logic cs2,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_en,
    output logic hiz_force
);
    logic sel;

    always_comb begin
        sel       = acc_en && !cs1_n && cs2;
        wr_en     = sel && !we_n;
        hiz_force = !(sel && we_n && !oe_n);
    end
endmodule

// File: rtl/pwr_guard_ctrl.sv
module pwr_guard_ctrl
    import pwr_guard_pkg::*;
#(
    parameter int REC_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_hi,
    input  logic sup_lo,
    input  logic sup_so,
    input  logic ms_tick,
    input  logic cs1_n,
    input  logic cs2,
    input  logic oe_n,
    input  logic we_n,
    input  logic day_roll,
    input  logic osc_run,
    input  logic batt_ok,
    input  logic blow_en,
    output logic acc_en,
    output logic wr_en,
    output logic hiz_force,
    output logic bat_sel,
    output logic batt_low
);
    pg_state_t state_q;
    logic      in_batt;
    logic      in_check;
    logic      in_active;

    pwr_guard_seq #(.REC_MS(REC_MS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_hi   (sup_hi),
        .sup_lo   (sup_lo),
        .sup_so   (sup_so),
        .ms_tick  (ms_tick),
        .state_q  (state_q),
        .in_batt  (in_batt),
        .in_check (in_check),
        .in_active(in_active)
    );

    // access withdrawn in the same cycle a threshold flag drops
    assign acc_en  = in_active && sup_hi && sup_lo;
    assign bat_sel = in_batt;

    pwr_guard_batt u_batt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_check (in_check),
        .in_active(in_active),
        .day_roll (day_roll),
        .osc_run  (osc_run),
        .batt_ok  (batt_ok),
        .blow_en  (blow_en),
        .batt_low (batt_low)
    );

    pwr_guard_decode u_dec (
        .acc_en   (acc_en),
        .cs1_n    (cs1_n),
        .cs2      (cs2),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_en    (wr_en),
        .hiz_force(hiz_force)
    );
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
    parameter int REC_MS = 100
) (
    input logic clk,
    input logic rst_n,
    input logic sup_hi,
    input logic sup_lo,
    input logic sup_so,
    input logic ms_tick,
    input logic batt_ok,
    input logic blow_en,
    input logic acc_en,
    input logic wr_en,
    input logic hiz_force,
    input logic bat_sel,
    input logic batt_low
);
    int hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             hi_run <= 0;
        else if (!sup_hi || !sup_lo)            hi_run <= 0;
        else if (ms_tick && hi_run < REC_MS)    hi_run <= hi_run + 1;
    end

    // R3
    supply_drop_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_hi || !sup_lo) |-> (!acc_en && !wr_en));

    // R2
    battery_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_so |=> bat_sel);

    // R4
    recovery_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> (hi_run >= REC_MS));

    // R6
    write_floats_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> hiz_force);

    // R8
    deselect_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (hiz_force && !wr_en));

    // R13
    no_check_on_battery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |=> $stable(batt_low));

    // R9
    flag_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_low) |-> ($past(!batt_ok) && $past(blow_en)));
endmodule

bind pwr_guard_ctrl pwr_guard_chk #(.REC_MS(REC_MS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_hi   (sup_hi),
    .sup_lo   (sup_lo),
    .sup_so   (sup_so),
    .ms_tick  (ms_tick),
    .batt_ok  (batt_ok),
    .blow_en  (blow_en),
    .acc_en   (acc_en),
    .wr_en    (wr_en),
    .hiz_force(hiz_force),
    .bat_sel  (bat_sel),
    .batt_low (batt_low)
);

// File: tb/pwr_guard_ctrl_test.sv
module pwr_guard_ctrl_test;
    localparam int RMS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_hi = 0, sup_lo = 0, sup_so = 0, ms_tick = 0;
    logic cs1_n = 1, cs2 = 0, oe_n = 1, we_n = 1;
    logic day_roll = 0, osc_run = 1, batt_ok = 1, blow_en = 1;
    logic acc_en, wr_en, hiz_force, bat_sel, batt_low;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_guard_ctrl #(.REC_MS(RMS)) uut (
        .clk(clk), .rst_n(rst_n), .sup_hi(sup_hi), .sup_lo(sup_lo), .sup_so(sup_so),
        .ms_tick(ms_tick), .cs1_n(cs1_n), .cs2(cs2), .oe_n(oe_n), .we_n(we_n),
        .day_roll(day_roll), .osc_run(osc_run), .batt_ok(batt_ok), .blow_en(blow_en),
        .acc_en(acc_en), .wr_en(wr_en), .hiz_force(hiz_force), .bat_sel(bat_sel),
        .batt_low(batt_low)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // supply to full level, count ticks, then the CHECK cycle
    task automatic power_up();
        sup_so = 1; cyc();
        sup_lo = 1; sup_hi = 1; cyc();
        ms_tick = 1;
        for (int i = 0; i < RMS; i++) cyc();
        ms_tick = 0; cyc();
    endtask

    task automatic pulse_day();
        day_roll = 1; cyc(); day_roll = 0; cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        chk("R1 acc_en", acc_en, 0);
        chk("R1 hiz_force", hiz_force, 1);
        chk("R1 bat_sel", bat_sel, 1);
        chk("R1 batt_low", batt_low, 0);
        rst_n = 1; cyc();
        chk("R1 bat_sel after release", bat_sel, 1);

        // R2 leave battery
        sup_so = 1; cyc();
        chk("R2 bat_sel off", bat_sel, 0);

        // R4 recovery timing, power-up with failing battery (R9)
        batt_ok = 0; blow_en = 1;
        sup_lo = 1; sup_hi = 1; cyc();
        for (int i = 0; i < 4; i++) begin
            cyc();
            chk("R4 no tick no access", acc_en, 0);
        end
        ms_tick = 1;
        for (int i = 0; i < RMS; i++) begin
            cyc();
            chk("R4 counting", acc_en, 0);
        end
        ms_tick = 0; cyc();
        chk("R4 access granted", acc_en, 1);
        chk("R9 power-up check sets flag", batt_low, 1);

        // R5 restart mid-recovery
        sup_hi = 0; cyc();
        chk("R3 access gone", acc_en, 0);
        sup_hi = 1; cyc();
        ms_tick = 1; cyc(); cyc();
        ms_tick = 0;
        sup_hi = 0; cyc();
        sup_hi = 1; cyc();
        ms_tick = 1;
        for (int i = 0; i < RMS - 1; i++) cyc();
        ms_tick = 0; cyc();
        chk("R5 count restarted", acc_en, 0);
        ms_tick = 1; cyc(); ms_tick = 0; cyc();
        chk("R5 access after full count", acc_en, 1);

        // R6 R7 exhaustive decode while granted
        for (int v = 0; v < 16; v++) begin
            {cs1_n, cs2, oe_n, we_n} = 4'(v);
            #1;
            chk("R6 wr_en", wr_en, int'(!cs1_n && cs2 && !we_n));
            chk("R7 hiz_force", hiz_force, int'(!(!cs1_n && cs2 && we_n && !oe_n)));
        end

        // R3 write aborted in the same cycle
        cs1_n = 0; cs2 = 1; oe_n = 1; we_n = 0; #1;
        chk("R6 write active", wr_en, 1);
        sup_hi = 0; #1;
        chk("R3 write aborted", wr_en, 0);
        chk("R3 acc_en dropped", acc_en, 0);
        sup_hi = 1; sup_lo = 0; #1;
        chk("R3 lower flag low", wr_en, 0);
        cyc();

        // R8 inputs ignored while protected
        for (int v = 0; v < 16; v++) begin
            {cs1_n, cs2, oe_n, we_n} = 4'(v);
            cyc();
            chk("R8 wr_en", wr_en, 0);
            chk("R8 hiz_force", hiz_force, 1);
        end
        cs1_n = 1; cs2 = 0; oe_n = 1; we_n = 1;
        sup_lo = 1; sup_hi = 1; cyc();
        ms_tick = 1;
        for (int i = 0; i < RMS; i++) cyc();
        ms_tick = 0; cyc();
        chk("R4 re-grant", acc_en, 1);
        chk("R12 flag kept across recheck fail", batt_low, 1);

        // R12 daily check passes clears
        batt_ok = 1; cyc(); cyc();
        chk("R12 no check no clear", batt_low, 1);
        pulse_day();
        chk("R12 passing daily check clears", batt_low, 0);
        // R11 oscillator stopped
        batt_ok = 0; osc_run = 0; pulse_day();
        chk("R11 no check with osc stopped", batt_low, 0);
        // R10 enable off
        osc_run = 1; blow_en = 0; pulse_day();
        chk("R10 disabled flag stays", batt_low, 0);
        blow_en = 1; pulse_day();
        chk("R11 daily check sets flag", batt_low, 1);

        // R13 battery mode, no checks
        sup_hi = 0; sup_lo = 0; sup_so = 0; cyc();
        chk("R2 bat_sel on", bat_sel, 1);
        batt_ok = 1; day_roll = 1;
        for (int i = 0; i < 5; i++) begin
            cyc();
            chk("R13 flag frozen on battery", batt_low, 1);
        end
        day_roll = 0;

        // R12 next power-up check passes
        power_up();
        chk("R4 access after power-up", acc_en, 1);
        chk("R12 power-up check clears", batt_low, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule